// File: doc/BRIEF.md
# Packed Fixed-Point Multiply Unit

This block multiplies two 64-bit packed operands lane by lane and combines the products in one of eight ways. The operand is viewed either as four 16-bit halfword lanes or as two 32-bit word lanes. The operations cover three groups: halfword products that are summed or subtracted in pairs into two word lanes; high-half results of halfword or word products, with or without round-to-nearest; and low-half results of halfword or word products. A separate control bit chooses whether each operand lane is treated as a two's-complement number or as an unsigned number.

The operands, the opcode and the signedness bit are qualified by `valid_i`, and all four are captured together. The result appears on `result_o`, with `valid_o` high, exactly two clock cycles later. A new operation can be issued on every cycle. While no result is being delivered, `result_o` keeps its last value.

Lane numbering is fixed throughout. Halfword lane j occupies bits 16j+15..16j, and word lane i occupies bits 32i+31..32i. Below, A and B are the lane values of `a_i` and `b_i`.

Top module: `pmul_unit`

## Requirements
- R1: When `valid_i` is high at a rising edge, `valid_o` is high and `result_o` holds that operation's result after the second rising edge that follows. When `valid_i` is low at a rising edge, `valid_o` is low after the second rising edge that follows. Operations issued on back-to-back cycles come out on back-to-back cycles.
- R2: While `rst_ni` is low, `valid_o` is low and `result_o` is zero.
- R3: Opcode 0 is the cross multiply-add. For each word lane i, the result is A[2i+1]·B[2i] + A[2i]·B[2i+1] on halfword lanes, taken modulo 2^32.
- R4: Opcode 1 is the straight multiply-subtract. For each word lane i, the result is A[2i]·B[2i] − A[2i+1]·B[2i+1] on halfword lanes, taken modulo 2^32.
- R5: When `sign_i` = 1, every operand lane is sign-extended before it is multiplied. When `sign_i` = 0, every operand lane is zero-extended. This applies to all opcodes.
- R6: Opcode 2 is the halfword high multiply. Each halfword lane j of the result is bits 31..16 of the 32-bit product A[j]·B[j].
- R7: Opcode 3 is the rounded halfword high multiply. Each halfword lane j of the result is (A[j]·B[j] + 0x8000) shifted right by 16, keeping 16 bits. The shift is arithmetic for signed operations and logical for unsigned ones.
- R8: Opcode 4 is the word high multiply: each word lane i of the result is bits 63..32 of the 64-bit product A[i]·B[i] on word lanes. Opcode 5 is the rounded form: it adds 2^31 to each product before taking bits 63..32.
- R9: Opcode 6 is the word low multiply. Each word lane i of the result is bits 31..0 of the word product, and this value is the same for either setting of `sign_i`.
- R10: Opcode 7 is the halfword low multiply. Each halfword lane j of the result is bits 15..0 of A[j]·B[j].
- R11: When no result is being delivered, `valid_o` is low and `result_o` keeps the value it had on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the operands, opcode and sign bit |
| op_i | input | 3 | Operation select (opcodes 0 to 7) |
| sign_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| valid_o | output | 1 | Result valid, two cycles after issue |
| result_o | output | 64 | Packed result |

## Verification
The bench targets operands where the signed and unsigned readings diverge most: 0x8000 and 0xFFFF halfwords, and 0x80000000 and all-ones words. A design that zero-extended where it should sign-extend would therefore produce a visibly wrong high half. Rounding ties are driven deliberately, because they expose a bias that was dropped or applied to the wrong bit. Cross multiply-add sums that wrap past 2^31 reveal a saturating or widened adder. Pairing the products the wrong way shows up as swapped word lanes. Random issue gaps test both the latency and the holding of the result: a skipped or extra pipeline stage, or a result register that loads on idle cycles, shows up as results on the wrong cycle or as values that drift while nothing is being delivered.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  typedef enum logic [2:0] {
    OP_XMADD  = 3'd0,  // cross pair multiply-add
    OP_SMSUB  = 3'd1,  // straight pair multiply-subtract
    OP_HMULH  = 3'd2,  // halfword high
    OP_HMULHR = 3'd3,  // halfword high, rounded
    OP_WMULH  = 3'd4,  // word high
    OP_WMULHR = 3'd5,  // word high, rounded
    OP_WMULL  = 3'd6,  // word low
    OP_HMULL  = 3'd7   // halfword low
  } pmul_op_e;

endpackage

// File: rtl/pmul_mult.sv
module pmul_mult #(
  parameter int unsigned W = 16
) (
  input  logic           sign_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);

  logic signed [2*W-1:0] a_x, b_x;

  // low 2W bits of the extended product are exact for either signedness
  assign a_x = {{W{sign_i & a_i[W-1]}}, a_i};
  assign b_x = {{W{sign_i & b_i[W-1]}}, b_i};
  assign p_o = a_x * b_x;

endmodule

// File: rtl/pmul_datapath.sv
module pmul_datapath
  import pmul_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned NUM_HW = 4
) (
  input  pmul_op_e                   op_i,
  input  logic                       sign_i,
  input  logic [LANE_W*NUM_HW-1:0]   a_i,
  input  logic [LANE_W*NUM_HW-1:0]   b_i,
  output logic [LANE_W*NUM_HW-1:0]   res_o
);

  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam int unsigned NUM_W  = NUM_HW / 2;
  localparam int unsigned DATA_W = LANE_W * NUM_HW;

  logic [LANE_W-1:0] b_sel [NUM_HW];
  logic [WORD_W-1:0] hp    [NUM_HW];
  logic [DATA_W-1:0] v_hh, v_hr, v_hl, v_xs, v_sd, v_wh, v_whr, v_wl;

  for (genvar j = 0; j < NUM_HW; j++) begin : g_half
    // cross op pairs each A lane with its neighbour's B lane
    assign b_sel[j] = (op_i == OP_XMADD) ? b_i[(j ^ 1)*LANE_W +: LANE_W]
                                         : b_i[j*LANE_W +: LANE_W];
    pmul_mult #(.W(LANE_W)) u_hmul (
      .sign_i (sign_i),
      .a_i    (a_i[j*LANE_W +: LANE_W]),
      .b_i    (b_sel[j]),
      .p_o    (hp[j])
    );
    assign v_hh[j*LANE_W +: LANE_W] = hp[j][WORD_W-1:LANE_W];
    // +half-LSB bias then truncate == carry in of bit LANE_W-1
    assign v_hr[j*LANE_W +: LANE_W] = hp[j][WORD_W-1:LANE_W]
                                    + {{(LANE_W-1){1'b0}}, hp[j][LANE_W-1]};
    assign v_hl[j*LANE_W +: LANE_W] = hp[j][LANE_W-1:0];
  end

  for (genvar i = 0; i < NUM_W; i++) begin : g_word
    logic [2*WORD_W-1:0] wp;
    assign v_xs[i*WORD_W +: WORD_W] = hp[2*i] + hp[2*i+1];
    assign v_sd[i*WORD_W +: WORD_W] = hp[2*i] - hp[2*i+1];
    pmul_mult #(.W(WORD_W)) u_wmul (
      .sign_i (sign_i),
      .a_i    (a_i[i*WORD_W +: WORD_W]),
      .b_i    (b_i[i*WORD_W +: WORD_W]),
      .p_o    (wp)
    );
    assign v_wh [i*WORD_W +: WORD_W] = wp[2*WORD_W-1:WORD_W];
    assign v_whr[i*WORD_W +: WORD_W] = wp[2*WORD_W-1:WORD_W]
                                     + {{(WORD_W-1){1'b0}}, wp[WORD_W-1]};
    assign v_wl [i*WORD_W +: WORD_W] = wp[WORD_W-1:0];
  end

  always_comb begin
    unique case (op_i)
      OP_XMADD:  res_o = v_xs;
      OP_SMSUB:  res_o = v_sd;
      OP_HMULH:  res_o = v_hh;
      OP_HMULHR: res_o = v_hr;
      OP_WMULH:  res_o = v_wh;
      OP_WMULHR: res_o = v_whr;
      OP_WMULL:  res_o = v_wl;
      OP_HMULL:  res_o = v_hl;
      default:   res_o = '0;
    endcase
  end

endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned NUM_HW = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [2:0]               op_i,
  input  logic                     sign_i,
  input  logic [LANE_W*NUM_HW-1:0] a_i,
  input  logic [LANE_W*NUM_HW-1:0] b_i,
  output logic                     valid_o,
  output logic [LANE_W*NUM_HW-1:0] result_o
);

  localparam int unsigned DATA_W = LANE_W * NUM_HW;

  logic              s1_v;
  pmul_op_e          op_q;
  logic              sign_q;
  logic [DATA_W-1:0] a_q, b_q, dp_res;

  // stage 1: capture operation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_v <= 1'b0;
    else         s1_v <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      op_q   <= pmul_op_e'(op_i);
      sign_q <= sign_i;
      a_q    <= a_i;
      b_q    <= b_i;
    end
  end

  pmul_datapath #(.LANE_W(LANE_W), .NUM_HW(NUM_HW)) u_dp (
    .op_i   (op_q),
    .sign_i (sign_q),
    .a_i    (a_q),
    .b_i    (b_q),
    .res_o  (dp_res)
  );

  // stage 2: result register, holds when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_v;
      if (s1_v) result_o <= dp_res;
    end
  end

  a_r1_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_v);
  a_r1_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !s1_v);
  a_r1_deliver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v |=> valid_o);
  a_r11_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_v |=> !valid_o);
  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_v |=> $stable(result_o));

endmodule

// File: tb/pmul_unit_tb_top.sv
module pmul_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_W = 16;
  localparam int NUM_HW = 4;
  localparam int DATA_W = LANE_W * NUM_HW;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [2:0]        op_i = '0;
  logic              sign_i = 1'b0;
  logic [DATA_W-1:0] a_i = '0, b_i = '0;
  logic              valid_o;
  logic [DATA_W-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  bit                h_v [2];
  logic [DATA_W-1:0] h_e [2];
  string             h_r [2];
  logic [DATA_W-1:0] last_res = '0;

  pmul_unit #(.LANE_W(LANE_W), .NUM_HW(NUM_HW)) dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .sign_i, .a_i, .b_i, .valid_o, .result_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] hmul(logic [15:0] a, logic [15:0] b, bit s);
    logic [31:0] ax, bx;
    ax = s ? {{16{a[15]}}, a} : {16'h0, a};
    bx = s ? {{16{b[15]}}, b} : {16'h0, b};
    return ax * bx;
  endfunction

  function automatic logic [63:0] wmul(logic [31:0] a, logic [31:0] b, bit s);
    logic [63:0] ax, bx;
    ax = s ? {{32{a[31]}}, a} : {32'h0, a};
    bx = s ? {{32{b[31]}}, b} : {32'h0, b};
    return ax * bx;
  endfunction

  function automatic logic [63:0] model(logic [2:0] op, bit s, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    logic [31:0] t;
    logic [63:0] w;
    r = '0;
    case (op)
      3'd0: for (int i = 0; i < 2; i++)   // R3
        r[32*i +: 32] = hmul(a[(2*i+1)*16 +: 16], b[2*i*16 +: 16], s)
                      + hmul(a[2*i*16 +: 16], b[(2*i+1)*16 +: 16], s);
      3'd1: for (int i = 0; i < 2; i++)   // R4
        r[32*i +: 32] = hmul(a[2*i*16 +: 16], b[2*i*16 +: 16], s)
                      - hmul(a[(2*i+1)*16 +: 16], b[(2*i+1)*16 +: 16], s);
      3'd2: for (int j = 0; j < 4; j++) begin  // R6
        t = hmul(a[16*j +: 16], b[16*j +: 16], s);
        r[16*j +: 16] = t[31:16];
      end
      3'd3: for (int j = 0; j < 4; j++) begin  // R7
        t = hmul(a[16*j +: 16], b[16*j +: 16], s) + 32'h8000;
        t = s ? 32'($signed(t) >>> 16) : (t >> 16);
        r[16*j +: 16] = t[15:0];
      end
      3'd4, 3'd5: for (int i = 0; i < 2; i++) begin  // R8
        w = wmul(a[32*i +: 32], b[32*i +: 32], s);
        if (op == 3'd5) w = w + 64'h8000_0000;
        r[32*i +: 32] = w[63:32];
      end
      3'd6: for (int i = 0; i < 2; i++) begin  // R9
        w = wmul(a[32*i +: 32], b[32*i +: 32], s);
        r[32*i +: 32] = w[31:0];
      end
      default: for (int j = 0; j < 4; j++) begin  // R10
        t = hmul(a[16*j +: 16], b[16*j +: 16], s);
        r[16*j +: 16] = t[15:0];
      end
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_out();
    n_chk++;
    if (valid_o !== h_v[1]) begin
      n_bad++;
      $display("FAIL R1 valid_o: actual %b expected %b", valid_o, h_v[1]);
    end
    n_chk++;
    if (h_v[1]) begin
      if (result_o !== h_e[1]) begin
        n_bad++;
        $display("FAIL %s result: actual %h expected %h", h_r[1], result_o, h_e[1]);
      end
    end else if (result_o !== last_res) begin
      n_bad++;
      $display("FAIL R11 hold: actual %h expected %h", result_o, last_res);
    end
    last_res = result_o;
  endtask

  // called at a falling edge; checks the op issued two steps earlier
  task automatic step(bit v, logic [2:0] op, bit s, logic [63:0] a, logic [63:0] b);
    check_out();
    h_v[1] = h_v[0]; h_e[1] = h_e[0]; h_r[1] = h_r[0];
    h_v[0] = v;
    h_e[0] = model(op, s, a, b);
    h_r[0] = s ? {req_of(op), " R5 signed"} : {req_of(op), " R5 unsigned"};
    valid_i = v; op_i = op; sign_i = s; a_i = a; b_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] pat [6];
    void'($urandom(32'd20461));
    h_v[0] = 0; h_v[1] = 0; h_e[0] = '0; h_e[1] = '0; h_r[0] = ""; h_r[1] = "";
    pat[0] = 64'h8000_8000_8000_8000;
    pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pat[2] = 64'h8000_0000_8000_0000;
    pat[3] = 64'h0001_0001_0001_0001;
    pat[4] = 64'h7FFF_0001_FFFF_8000;
    pat[5] = 64'h0000_0000_0000_0000;

    repeat (3) @(negedge clk_i);
    // R2: reset state
    n_chk++;
    if (valid_o !== 1'b0 || result_o !== '0) begin
      n_bad++;
      $display("FAIL R2 reset: actual %b/%h expected 0/0", valid_o, result_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners: every opcode, both signs, extreme patterns
    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 2; s++)
        for (int pa = 0; pa < 6; pa++)
          for (int pb = 0; pb < 6; pb += 2)
            step(1'b1, 3'(op), s[0], pat[pa], pat[pb]);

    // rounding ties (R7): product low half exactly 0x8000
    step(1'b1, 3'd3, 1'b0, 64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000);
    step(1'b1, 3'd3, 1'b1, 64'h0001_0001_0001_0001, 64'h8000_8000_8000_8000);
    step(1'b1, 3'd3, 1'b1, 64'h0003_FFFD_0003_FFFF, 64'h8000_8000_4000_C000);
    // word tie (R8)
    step(1'b1, 3'd5, 1'b1, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_8000_0000);
    step(1'b1, 3'd5, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_8000_0000);
    // R9 sign independence on same operands
    step(1'b1, 3'd6, 1'b0, 64'hDEAD_BEEF_8000_0001, 64'hF00D_CAFE_FFFF_FFFF);
    step(1'b1, 3'd6, 1'b1, 64'hDEAD_BEEF_8000_0001, 64'hF00D_CAFE_FFFF_FFFF);
    // R11: idle cycles hold the last result
    repeat (4) step(1'b0, 3'd0, 1'b0, '0, '0);
    // R3 lane pairing: distinct lane values
    step(1'b1, 3'd0, 1'b0, 64'h0004_0003_0002_0001, 64'h0040_0030_0020_0010);
    step(1'b1, 3'd1, 1'b1, 64'h0004_0003_0002_0001, 64'h0040_0030_0020_0010);

    // random stream with gaps (R1 back-to-back and idle)
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 3'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (3) step(1'b0, 3'd0, 1'b0, '0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule